// File: doc/BRIEF.md
# Interrupt and DMA Request Router

This block collects the interrupt events of a memory-card host controller. It holds a 13-bit sticky request register and a 13-bit mask register. From these it drives one level-sensitive interrupt line to the CPU and two DMA request lines, one for the receive FIFO and one for the transmit FIFO. The data path and the command path raise single-cycle event pulses that set request bits. FIFO accesses and clock-control commands clear particular bits.

A registered DMA-enable bit, taken from the controller's command/data control word, changes the routing of the two FIFO-service requests. When the bit is set, those two requests drive the DMA lines and are kept off the CPU interrupt, whatever the mask holds. When the bit is clear, both DMA lines stay low and the two requests reach the CPU interrupt through the mask like any other bit.

Software reaches the mask and request registers through a plain one-cycle register port. The request register is read-only from this port. No data stream crosses the block, so every pin is a plain control or status signal, and the port has no valid/ready handshake.

Top module: `intr_dma_router`

## Requirements
- R1: After reset the request register and the mask register are zero, and the interrupt and both DMA request outputs are low.
- R2: A pulse on event input bit i sets request bit i at the next clock edge. The bit then stays set until a clear action for that bit occurs. Bit 4 is clock-off, bit 5 is receive service and bit 6 is transmit service.
- R3: A write with `reg_sel` = 0 loads the low 13 bits of `reg_wdata` into the mask register. When the mask is read back, bits 31..13 are zero.
- R4: One cycle after any update, `irq` is high exactly when some request bit is set and its effective mask bit is 0. A mask bit of 1 suppresses its request.
- R5: While the registered DMA-enable is 1, request bits 5 and 6 do not assert `irq`, even when their mask bits are 0.
- R6: While the registered DMA-enable is 1, `dma_rx_req` equals request bit 5 and `dma_tx_req` equals request bit 6. While it is 0, both outputs are low.
- R7: A pulse on `rx_fifo_rd` clears request bit 5, and a pulse on `tx_fifo_wr` clears request bit 6.
- R8: A pulse on `clk_start` clears request bit 4, and a pulse on `clk_stop` sets it. If both pulse in the same cycle, the bit ends up set.
- R9: When an event set and a clear action hit the same request bit in the same cycle, the bit ends up set.
- R10: A write with `reg_sel` = 1 targets the request register and changes nothing.
- R11: `reg_rdata` shows the mask register when `reg_sel` = 0 and the request register when `reg_sel` = 1, zero-extended, with no read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 mask, 1 request |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected register |
| dma_en | input | 1 | DMA-enable bit from the command/data control word |
| evt_set | input | 13 | Per-bit event pulses that set request bits |
| rx_fifo_rd | input | 1 | Receive FIFO read, clears bit 5 |
| tx_fifo_wr | input | 1 | Transmit FIFO write, clears bit 6 |
| clk_start | input | 1 | Clock-start command, clears bit 4 |
| clk_stop | input | 1 | Clock-stop command, sets bit 4 |
| irq | output | 1 | Level interrupt to the CPU |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The bench aims first at the collision cases. An event on bit 5 together with a receive FIFO read must leave the bit set, and clock-start together with clock-stop must leave the clock-off bit set. A design that gave clear actions priority would lose a service request that was raised again in the same cycle. The DMA-enable bit is toggled while bits 5 and 6 are pending with their mask bits open. A router that leaked service requests to the CPU would raise a spurious interrupt, and one that ignored the enable would drive DMA lines with no engine listening. Writes of all ones to the mask, and writes aimed at the read-only request register, show up respectively as stray upper bits on readback and as bits that disappear.

// File: rtl/intr_router_pkg.sv
package intr_router_pkg;
  localparam int NUM_SRC    = 13;
  localparam int DATA_W     = 32;
  localparam int CLKOFF_BIT = 4;
  localparam int RX_BIT     = 5;
  localparam int TX_BIT     = 6;

  typedef enum logic {
    SEL_MASK = 1'b0,
    SEL_REQ  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/intr_req_reg.sv
module intr_req_reg
  import intr_router_pkg::*;
#(
  parameter int N      = NUM_SRC,
  parameter int RX     = RX_BIT,
  parameter int TX     = TX_BIT,
  parameter int CLKOFF = CLKOFF_BIT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_set,
  input  logic         rx_pop,
  input  logic         tx_push,
  input  logic         clk_on,
  input  logic         clk_off,
  output logic [N-1:0] req_q
);
  logic [N-1:0] set_vec;
  logic [N-1:0] clr_vec;

  always_comb begin
    set_vec = evt_set;
    set_vec[CLKOFF] = evt_set[CLKOFF] | clk_off;
    clr_vec = '0;
    clr_vec[RX] = rx_pop;
    clr_vec[TX] = tx_push;
    clr_vec[CLKOFF] = clk_on;
  end

  for (genvar b = 0; b < N; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          req_q[b] <= 1'b0;
      else if (set_vec[b]) req_q[b] <= 1'b1;
      else if (clr_vec[b]) req_q[b] <= 1'b0;
    end
  end

  // R2
  evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((req_q & $past(evt_set)) == $past(evt_set)));
  // R7
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && !evt_set[RX]) |=> !req_q[RX]);
  // R7
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && !evt_set[TX]) |=> !req_q[TX]);
  // R8
  clk_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_off |=> req_q[CLKOFF]);
endmodule

// File: rtl/intr_mask_reg.sv
module intr_mask_reg
  import intr_router_pkg::*;
#(
  parameter int N = NUM_SRC,
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [N-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= wdata[N-1:0];
  end

  // R3
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mask_q == $past(wdata[N-1:0])));
endmodule

// File: rtl/intr_route.sv
module intr_route
  import intr_router_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int RX = RX_BIT,
  parameter int TX = TX_BIT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dma_en,
  input  logic [N-1:0] req_q,
  input  logic [N-1:0] mask_q,
  output logic         dma_q,
  output logic         irq,
  output logic         dma_rx_req,
  output logic         dma_tx_req
);
  logic [N-1:0] svc_mask;
  logic [N-1:0] eff_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dma_q <= 1'b0;
    else        dma_q <= dma_en;
  end

  always_comb begin
    svc_mask = '0;
    svc_mask[RX] = dma_q;
    svc_mask[TX] = dma_q;
    eff_mask = mask_q | svc_mask;
  end

  assign irq        = |(req_q & ~eff_mask);
  assign dma_rx_req = dma_q & req_q[RX];
  assign dma_tx_req = dma_q & req_q[TX];
endmodule

// File: rtl/intr_dma_router.sv
module intr_dma_router
  import intr_router_pkg::*;
#(
  parameter int N = NUM_SRC,
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic         reg_sel,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         dma_en,
  input  logic [N-1:0] evt_set,
  input  logic         rx_fifo_rd,
  input  logic         tx_fifo_wr,
  input  logic         clk_start,
  input  logic         clk_stop,
  output logic         irq,
  output logic         dma_rx_req,
  output logic         dma_tx_req
);
  logic [N-1:0] req_q;
  logic [N-1:0] mask_q;
  logic         dma_q;
  logic         mask_wr;

  assign mask_wr = reg_wr && (reg_sel == SEL_MASK);

  intr_req_reg #(.N(N), .RX(RX_BIT), .TX(TX_BIT), .CLKOFF(CLKOFF_BIT)) i_req (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .rx_pop(rx_fifo_rd),
    .tx_push(tx_fifo_wr), .clk_on(clk_start), .clk_off(clk_stop), .req_q(req_q)
  );

  intr_mask_reg #(.N(N), .W(W)) i_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(mask_wr), .wdata(reg_wdata), .mask_q(mask_q)
  );

  intr_route #(.N(N), .RX(RX_BIT), .TX(TX_BIT)) i_route (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .req_q(req_q), .mask_q(mask_q),
    .dma_q(dma_q), .irq(irq), .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_sel == SEL_REQ) reg_rdata[N-1:0] = req_q;
    else                    reg_rdata[N-1:0] = mask_q;
  end

  // R10
  req_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && !(|evt_set) && !rx_fifo_rd && !tx_fifo_wr &&
     !clk_start && !clk_stop) |=> $stable(req_q));
  // R6
  dma_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_q |-> (!dma_rx_req && !dma_tx_req));
  // R5
  svc_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_q && ((req_q & ~(N'(1) << RX_BIT) & ~(N'(1) << TX_BIT)) == '0)) |-> !irq);
  // R3
  mask_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (reg_rdata[W-1:N] == '0));
endmodule

// File: tb/test_intr_dma_router.sv
module test_intr_dma_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dma_en = 1'b0;
  logic [12:0] evt_set = '0;
  logic        rx_fifo_rd = 1'b0;
  logic        tx_fifo_wr = 1'b0;
  logic        clk_start = 1'b0;
  logic        clk_stop = 1'b0;
  logic        irq, dma_rx_req, dma_tx_req;

  int checks = 0;
  int errors = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  int m_req = 0;
  int m_mask = 0;
  int m_dma = 0;

  always #5 clk = ~clk;

  intr_dma_router i_intr_dma_router (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_en(dma_en),
    .evt_set(evt_set), .rx_fifo_rd(rx_fifo_rd), .tx_fifo_wr(tx_fifo_wr),
    .clk_start(clk_start), .clk_stop(clk_stop), .irq(irq),
    .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, advanced at every rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_req = 0; m_mask = 0; m_dma = 0;
    end else begin
      int setv, clrv;
      if (reg_wr && !reg_sel) m_mask = int'(reg_wdata) & 'h1fff;
      clrv = (rx_fifo_rd ? 'h20 : 0) | (tx_fifo_wr ? 'h40 : 0) | (clk_start ? 'h10 : 0);
      setv = int'(evt_set) | (clk_stop ? 'h10 : 0);
      m_req = (m_req & ~clrv) | setv;
      m_dma = dma_en ? 1 : 0;
    end
  end

  function automatic int exp_irq();
    int hide;
    hide = m_mask | (m_dma != 0 ? 'h60 : 0);
    return ((m_req & ~hide) != 0) ? 1 : 0;
  endfunction

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    if (live) begin
      #2;
      check("R4 irq", int'(irq), exp_irq());
      check("R6 dma_rx", int'(dma_rx_req), (m_dma != 0) ? ((m_req >> 5) & 1) : 0);
      check("R6 dma_tx", int'(dma_tx_req), (m_dma != 0) ? ((m_req >> 6) & 1) : 0);
      check("R11 rdata", int'(reg_rdata), reg_sel ? m_req : m_mask);
    end
  end

  task automatic idle();
    reg_wr = 0; evt_set = '0; rx_fifo_rd = 0; tx_fifo_wr = 0;
    clk_start = 0; clk_stop = 0;
  endtask

  // Hold the current stimulus over one rising edge, then release it.
  task automatic cycle();
    @(negedge clk);
    idle();
    #3;
  endtask

  task automatic peek(logic sel, output int val);
    reg_sel = sel;
    #1;
    val = int'(reg_rdata);
  endtask

  task automatic write(logic sel, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    cycle();
  endtask

  task automatic pulse(logic [12:0] ev, bit rx, bit tx, bit start, bit stop);
    @(negedge clk);
    evt_set = ev; rx_fifo_rd = rx; tx_fifo_wr = tx; clk_start = start; clk_stop = stop;
    cycle();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    live = 1;
    #3;
    // R1 reset state
    check("R1 irq", int'(irq), 0);
    check("R1 dma", int'({dma_rx_req, dma_tx_req}), 0);
    peek(1, v); check("R1 req", v, 0);
    peek(0, v); check("R1 mask", v, 0);

    // R2 sticky set, R4 unmasked interrupt
    pulse(13'h0001, 0, 0, 0, 0);
    peek(1, v); check("R2 req bit0", v, 'h1);
    check("R4 irq from bit0", int'(irq), 1);
    repeat (3) @(negedge clk);
    #3;
    peek(1, v); check("R2 bit0 held", v, 'h1);

    // R3 mask keeps low 13 bits; R4 fully masked
    write(0, 32'hFFFF_FFFF);
    peek(0, v); check("R3 mask readback", v, 'h1fff);
    check("R4 irq masked", int'(irq), 0);
    write(0, 32'h0000_0000);
    peek(0, v); check("R3 mask cleared", v, 0);

    // R5/R6 DMA routing of the receive service bit
    write(0, 32'h0000_0001);   // hide bit0 so only service bits matter
    @(negedge clk); dma_en = 1;
    pulse(13'h0020, 0, 0, 0, 0);
    check("R5 rx hidden from irq", int'(irq), 0);
    check("R6 dma_rx follows bit5", int'(dma_rx_req), 1);
    check("R6 dma_tx idle", int'(dma_tx_req), 0);
    pulse(13'h0040, 0, 0, 0, 0);
    check("R6 dma_tx follows bit6", int'(dma_tx_req), 1);
    check("R5 tx hidden from irq", int'(irq), 0);
    @(negedge clk); dma_en = 0;
    @(negedge clk); #3;
    check("R6 dma lines low when off", int'({dma_rx_req, dma_tx_req}), 0);
    check("R5 service reaches irq when off", int'(irq), 1);

    // R7 FIFO accesses clear the service bits
    pulse(13'h0000, 1, 0, 0, 0);
    peek(1, v); check("R7 rx cleared", v & 'h60, 'h40);
    pulse(13'h0000, 0, 1, 0, 0);
    peek(1, v); check("R7 tx cleared", v & 'h60, 0);

    // R8 clock start/stop on the clock-off bit
    pulse(13'h0000, 0, 0, 0, 1);
    peek(1, v); check("R8 stop sets bit4", v & 'h10, 'h10);
    pulse(13'h0000, 0, 0, 1, 0);
    peek(1, v); check("R8 start clears bit4", v & 'h10, 0);
    pulse(13'h0000, 0, 0, 1, 1);
    peek(1, v); check("R8 stop wins", v & 'h10, 'h10);

    // R9 set beats clear on the same bit
    pulse(13'h0060, 1, 1, 0, 0);
    peek(1, v); check("R9 set wins on 5 and 6", v & 'h60, 'h60);
    pulse(13'h0010, 0, 0, 1, 0);
    peek(1, v); check("R9 event wins over start", v & 'h10, 'h10);

    // R10 request register ignores writes
    peek(1, v);
    write(1, 32'h0000_0000);
    begin
      int w;
      peek(1, w); check("R10 write to req ignored", w, v);
    end
    write(1, 32'h0000_1FFF);
    begin
      int w;
      peek(1, w); check("R10 write ones ignored", w, v);
    end

    // R11 select switches instantly
    write(0, 32'h0000_0AAA);
    peek(0, v); check("R11 mask view", v, 'h0aaa);
    peek(1, v); check("R11 req view", v, m_req);
    pulse(13'h1000, 0, 0, 0, 0);
    check("R4 irq from bit12", int'(irq), 1);

    repeat (4) @(negedge clk);
    live = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule